// File: doc/BRIEF.md
# Interrupt Pin Configuration and Alert Logging

This block holds a 16-bit configuration word and drives one shared interrupt pin from it. A two-bit mode field picks what the pin reports: nothing, the converter's busy state, or pending alerts. A polarity bit decides whether "active" is a high or a low level. Alongside the pin, the block keeps a sticky alert status vector with one bit per channel, and an alert flag that is the OR of that vector.

Software writes the word through whatever serial port sits in front of the block, using a write strobe and 16 data bits. Writing 1 to both mode bits is a command, not a stored mode. It empties the alert status in one step and leaves the pin in alert mode. The alert events come as one-cycle pulses from the comparators upstream.

Top module: `intr_pin_ctl`

## Requirements
- R1: After reset the readback is 0x0000, the alert status and flag are 0, and the pin sits at its inactive level for active-low polarity, which is 1.
- R2: A write stores data bits [14:0], and they read back from the edge that takes the write. Bit 15 is reserved: it always reads 0 and ignores writes.
- R3: With mode bits [2:1] = 00 the pin holds its inactive level, whatever busy and the alerts do.
- R4: With mode bits [2:1] = 01 the pin is active exactly while busy_i is 1. The path is combinational, with no register delay.
- R5: With mode bits [2:1] = 10 the pin is active exactly while the alert flag is 1.
- R6: Bit 0 sets polarity. With 1 the active level is high; with 0 it is low. The inactive level is always the opposite of the active one.
- R7: A pulse on alert_ev_i[i] sets status bit i at that clock edge. The bit stays set through idle cycles and through non-clearing writes.
- R8: alert_flag_o is 1 exactly when at least one status bit is 1.
- R9: A write with bits [2:1] = 11 clears all status bits and the flag at that edge. The mode then reads back as 10, and the other bits are stored as written.
- R10: An alert event in the same cycle as a clearing write is dropped, because the clear takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 16 | Configuration write data |
| rd_data_o | output | 16 | Configuration readback |
| busy_i | input | 1 | Converter busy indication |
| alert_ev_i | input | NUM_CH | One-cycle alert event per channel |
| pin_o | output | 1 | Shared interrupt pin level |
| alert_flag_o | output | 1 | OR of all alert status bits |
| alert_status_o | output | NUM_CH | Sticky per-channel alert status |

## Verification
Writes, clears and alert events take effect at the clock edge that samples them. Readback, status and flag are therefore due one edge after the stimulus, and the bench drives on a falling edge and samples on the next falling edge. The pin is combinational in busy_i and in the stored state. Busy checks are therefore sampled 1 ns after busy changes, inside the same cycle. The mode/polarity/busy/flag sweep computes the expected pin level as polarity XNOR active.

// File: rtl/intr_pin_pkg.sv
package intr_pin_pkg;
  localparam int unsigned CFG_W    = 16;
  localparam int unsigned POL_BIT  = 0;
  localparam int unsigned MODE_LO  = 1;
  localparam int unsigned MODE_HI  = 2;
  localparam int unsigned RSV_BIT  = 15;

  typedef enum logic [1:0] {
    PIN_OFF   = 2'b00,
    PIN_BUSY  = 2'b01,
    PIN_ALERT = 2'b10,
    PIN_CLEAR = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/intr_rst_sync.sv
module intr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/intr_cfg_reg.sv
module intr_cfg_reg
  import intr_pin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             clear_o
);
  localparam logic [CFG_W-1:0] WR_MASK = ~(CFG_W'(1) << RSV_BIT);

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             cfg_en;
  logic             is_clear;

  always_comb begin
    is_clear = wr_en_i && (pin_mode_e'(wr_data_i[MODE_HI:MODE_LO]) == PIN_CLEAR);
    cfg_en   = wr_en_i;
    cfg_d    = wr_data_i & WR_MASK;
    if (is_clear) begin
      cfg_d[MODE_HI:MODE_LO] = PIN_ALERT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o   = cfg_q;
  assign clear_o = is_clear;
endmodule

// File: rtl/intr_alert_log.sv
module intr_alert_log #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic [NUM_CH-1:0] event_i,
  output logic [NUM_CH-1:0] status_o,
  output logic              flag_o
);
  logic [NUM_CH-1:0] status_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic bit_d, bit_en;

    always_comb begin
      bit_en = clear_i || event_i[ch];
      bit_d  = !clear_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_q[ch] <= 1'b0;
      end else if (bit_en) begin
        status_q[ch] <= bit_d;
      end
    end
  end

  assign status_o = status_q;
  assign flag_o   = |status_q;
endmodule

// File: rtl/intr_pin_drive.sv
module intr_pin_drive
  import intr_pin_pkg::*;
(
  input  pin_mode_e mode_i,
  input  logic      pol_i,
  input  logic      busy_i,
  input  logic      flag_i,
  output logic      pin_o
);
  logic active;

  always_comb begin
    unique case (mode_i)
      PIN_BUSY:  active = busy_i;
      PIN_ALERT: active = flag_i;
      default:   active = 1'b0;
    endcase
    pin_o = pol_i ? active : !active;
  end
endmodule

// File: rtl/intr_pin_ctl.sv
module intr_pin_ctl
  import intr_pin_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [15:0]       wr_data_i,
  output logic [15:0]       rd_data_o,
  input  logic              busy_i,
  input  logic [NUM_CH-1:0] alert_ev_i,
  output logic              pin_o,
  output logic              alert_flag_o,
  output logic [NUM_CH-1:0] alert_status_o
);
  logic             rst_sync_n;
  logic [CFG_W-1:0] cfg;
  logic             clear;

  intr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  intr_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .clear_o   (clear)
  );

  intr_alert_log #(.NUM_CH(NUM_CH)) u_log (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clear_i  (clear),
    .event_i  (alert_ev_i),
    .status_o (alert_status_o),
    .flag_o   (alert_flag_o)
  );

  intr_pin_drive u_drv (
    .mode_i (pin_mode_e'(cfg[MODE_HI:MODE_LO])),
    .pol_i  (cfg[POL_BIT]),
    .busy_i (busy_i),
    .flag_i (alert_flag_o),
    .pin_o  (pin_o)
  );

  assign rd_data_o = cfg;
endmodule

// File: rtl/intr_pin_chk.sv
module intr_pin_chk #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [15:0]       wr_data_i,
  input logic [15:0]       rd_data_o,
  input logic              busy_i,
  input logic [NUM_CH-1:0] alert_ev_i,
  input logic              pin_o,
  input logic              alert_flag_o,
  input logic [NUM_CH-1:0] alert_status_o
);
  logic clr_wr;
  assign clr_wr = wr_en_i && (wr_data_i[2:1] == 2'b11);

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[15] == 1'b0); // R2

  AST_NO_CLEAR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[2:1] != 2'b11); // R9

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (alert_status_o == '0 && !alert_flag_o)); // R9

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((alert_status_o & $past(alert_status_o)) == $past(alert_status_o))); // R7

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && (|alert_ev_i)) |=> ((alert_status_o & $past(alert_ev_i)) == $past(alert_ev_i))); // R7

  AST_PIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[2:1] == 2'b00) |-> (pin_o == !rd_data_o[0])); // R3

  AST_PIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[2:1] == 2'b01) |-> (pin_o == (busy_i ~^ rd_data_o[0]))); // R4

  AST_PIN_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[2:1] == 2'b10) |-> (pin_o == ((|alert_status_o) ~^ rd_data_o[0]))); // R5
endmodule

bind intr_pin_ctl intr_pin_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/sim_intr_pin_ctl.sv
module sim_intr_pin_ctl;
  localparam int unsigned NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [15:0]    wr_data = '0;
  logic [15:0]    rd_data;
  logic           busy = 1'b0;
  logic [NCH-1:0] ev = '0;
  logic           pin, flag;
  logic [NCH-1:0] status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = !clk;

  intr_pin_ctl #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .busy_i(busy), .alert_ev_i(ev), .pin_o(pin),
    .alert_flag_o(flag), .alert_status_o(status)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, the next rising edge takes it, return at the next falling edge.
  task automatic wr(logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(logic [NCH-1:0] e);
    ev = e;
    @(negedge clk);
    ev = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 readback", rd_data, 32'h0);
    check("R1 status", status, 0);
    check("R1 flag", flag, 0);
    check("R1 pin", pin, 1);

    // R2 / R9 readback patterns
    begin
      logic [15:0] pats [6] = '{16'hFFFF, 16'h8001, 16'h5AA4, 16'hA552, 16'h7FF8, 16'h0006};
      foreach (pats[i]) begin
        logic [15:0] e;
        wr(pats[i]);
        e = pats[i] & 16'h7FFF;
        if (e[2:1] == 2'b11) e[2:1] = 2'b10;
        check("R2 R9 readback", rd_data, e);
      end
    end

    // R3..R6, R8 sweep: polarity x mode x flag state x busy
    for (int pol = 0; pol < 2; pol++) begin
      for (int md = 0; md < 3; md++) begin
        for (int st = 0; st < 2; st++) begin
          wr(16'(6 | pol));          // clear, alert mode
          if (st != 0) pulse(4'b0100);
          check("R8 flag", flag, st);
          wr(16'((md << 1) | pol));
          for (int b = 0; b < 2; b++) begin
            logic act, exp;
            busy = b[0];
            #1;
            act = (md == 1) ? b[0] : (md == 2) ? st[0] : 1'b0;
            exp = pol[0] ? act : !act;
            check(md == 0 ? "R3 R6 pin" : md == 1 ? "R4 R6 pin" : "R5 R6 pin", pin, exp);
          end
          busy = 1'b0;
          @(negedge clk);
        end
      end
    end

    // R7 sticky accumulation per channel
    wr(16'h0006);
    begin
      logic [NCH-1:0] exp_st = '0;
      for (int c = 0; c < NCH; c++) begin
        pulse(NCH'(1) << c);
        exp_st |= NCH'(1) << c;
        check("R7 set", status, exp_st);
      end
      repeat (5) @(negedge clk);
      check("R7 hold idle", status, exp_st);
      wr(16'h0002);
      check("R7 hold write", status, exp_st);
      check("R8 flag set", flag, 1);
    end

    // R9 clear drives pin inactive (active-high polarity)
    wr(16'h0005);
    check("R9 pin before", pin, 1);
    wr(16'h0007);
    check("R9 status", status, 0);
    check("R9 flag", flag, 0);
    check("R9 pin after", pin, 0);
    check("R9 mode", rd_data, 32'h0005);

    // R10 event coincident with clear is dropped, next one lands
    pulse(4'b0001);
    wr_en = 1'b1; wr_data = 16'h0006; ev = 4'b0010;
    @(negedge clk);
    wr_en = 1'b0; ev = '0;
    check("R10 dropped", status, 0);
    pulse(4'b1000);
    check("R10 after", status, 4'b1000);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule